// File: doc/BRIEF.md
# Multi-channel match timer

A register-mapped timer with four counters that share a single prescaler. Each counter counts up or down on the ticks the prescaler produces. It is compared against its own match value. When the two are equal, the timer can set a flag, reload the counter with zero, or halt the counter. A single level interrupt is raised from the flags whose interrupt enable is set.

Software reaches every register through a 16-byte slot. Address bits 3:2 pick how a write is applied:
- 0: the value is replaced.
- 1: the written ones are ORed in.
- 2: the written ones are cleared.
- 3: the written ones are inverted.

Because of this, a single write can change one field without a read-modify-write sequence. The bus is a plain synchronous port. A write is taken on the clock edge while `bus_we` is high. Read data is combinational from the address.

Top module: `mtm_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register, counter and the prescale counter becomes 0. After reset, every slot reads 0 and `irq` is 0.
- R2: Address bits above bit 3 select the slot. Address bits 3:2 select how a write is applied: 0 replaces the value, 1 ORs in the written bits, 2 clears the written bits, 3 inverts the written bits. A read from any of the four addresses of a slot returns that slot's stored value. The direction slot (0x020) is a 16-bit read/write field.
- R3: The prescale value is at 0x070 and the prescale count is read-only at 0x080. While any enable bit is set, the prescale count rises by one each cycle. On a cycle where the prescale count is at or above the prescale value, a tick is produced and the count returns to 0. An enabled counter therefore advances once every prescale value + 1 cycles.
- R4: Bit n of the control slot (0x010) enables counter n. A disabled counter keeps its value. While no counter is enabled, the prescale count also keeps its value.
- R5: Bit 4+n of the control slot holds counter n and the prescale count at 0 from the next clock edge. They stay at 0 for as long as the bit is 1. Counting resumes once the bit is cleared.
- R6: The direction slot (0x020) has a 4-bit field for counter n at bit 4n. Field value 1 counts down; any other value counts up. Counters wrap modulo 2^CNT_W in both directions.
- R7: Counter n reads at 0x030 + 0x10·n. Writes to the counter slots and to the prescale count slot are ignored. Unused slots read 0 and ignore writes.
- R8: On a tick where counter n is enabled, not held, and equal to its match value (0x0A0 + 0x10·n), flag n (bit n of slot 0x000) is set.
- R9: When match-control (0x090) bit 3n+1 is set, a match on counter n loads 0 instead of stepping. This gives a period of match value + 1 ticks.
- R10: When match-control bit 3n+2 is set, a match on counter n keeps the counter at its value and clears enable bit n. If bit 3n+1 is also set, the counter becomes 0.
- R11: Writing a 1 through the replace address of the flag slot clears that flag; writing a 0 keeps it. The other three addresses act bitwise as in R2. Bit 4 is a status bit that only software changes. A match sets its flag even when a write clears that flag on the same edge.
- R12: `irq` is the OR of flag n AND match-control bit 3n over all counters. Bit 4 of the flag slot does not contribute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address: slot in bits above 3, write mode in bits 3:2 |
| bus_we | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Stored value of the addressed slot, zero-extended |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with CNT_W = 8 and ADDR_W = 12. With an 8-bit counter, both the up and the down wrap happen within a few hundred cycles, so the modulo behaviour is checked directly. Prescale values 0 to 3 are swept over twelve consecutive cycles each, against counts computed as quotient and remainder. All four write modes are swept over sixteen value pairs on the direction slot. Match timing is checked cycle by cycle, including a flag clear that lands on the same edge as a match.

// File: rtl/mtm_pkg.sv
// Shared constants and helpers for the multi-channel match timer.
// Assumes a fixed register map of 16-byte slots; bits 3:2 choose the write mode.
package mtm_pkg;

    localparam int NCH     = 4;   // channels held by the register map
    localparam int SL_FLAG = 0;   // 0x000 flags
    localparam int SL_CTRL = 1;   // 0x010 enable / hold-reset
    localparam int SL_DIR  = 2;   // 0x020 direction fields
    localparam int SL_CNT0 = 3;   // 0x030.. counters
    localparam int SL_PRE  = 7;   // 0x070 prescale value
    localparam int SL_PCNT = 8;   // 0x080 prescale count
    localparam int SL_MCTL = 9;   // 0x090 match actions
    localparam int SL_MR0  = 10;  // 0x0A0.. match values
    localparam int NSLOT   = 14;

    typedef enum logic [1:0] {
        WM_REPLACE = 2'd0,
        WM_OR      = 2'd1,
        WM_ANDN    = 2'd2,
        WM_XOR     = 2'd3
    } wmode_e;

    // Applies one write in the chosen mode to a register value.
    function automatic logic [31:0] apply_write(input logic [31:0] cur,
                                                input logic [31:0] wd,
                                                input wmode_e mode);
        case (mode)
            WM_OR:   return cur | wd;
            WM_ANDN: return cur & ~wd;
            WM_XOR:  return cur ^ wd;
            default: return wd;
        endcase
    endfunction

endpackage

// File: rtl/mtm_prescale.sv
// Shared prescaler: counts cycles while any channel runs and emits a tick
// once the count reaches the programmed limit, then restarts from zero.
// Assumes clr has priority over counting; limit may change at any time.
module mtm_prescale #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] pc,
    output logic             tick
);

    logic [CNT_W-1:0] pc_q;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Tick whenever the count has reached or passed the limit.
    assign tick = run && (pc_q >= limit);
    assign pc   = pc_q;

    // Prescale count register.
    always_ff @(posedge clk) begin
        if (!rst_n)    pc_q <= '0;
        else if (clr)  pc_q <= '0;
        else if (tick) pc_q <= '0;
        else if (run)  pc_q <= pc_q + ONE;
    end

    // R5
    presc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pc_q == '0));
    // R3
    presc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pc_q == '0));
    // R4
    presc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(pc_q));

endmodule

// File: rtl/mtm_channel.sv
// One counter channel: steps up or down on prescaler ticks, compares with its
// match value and applies the reload / halt actions on a match.
// Assumes the match is judged on the value held before the step.
module mtm_channel #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hold_rst,
    input  logic             tick,
    input  logic             down,
    input  logic [CNT_W-1:0] mval,
    input  logic             act_reload,
    input  logic             act_halt,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);

    logic [CNT_W-1:0] cnt_q;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Match event for this tick.
    assign hit = en && !hold_rst && tick && (cnt_q == mval);
    assign cnt = cnt_q;

    // Counter register with hold-reset, match actions and stepping.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (hold_rst)           cnt_q <= '0;
        else if (hit && act_reload)  cnt_q <= '0;
        else if (hit && act_halt)    cnt_q <= cnt_q;
        else if (en && tick)         cnt_q <= down ? cnt_q - ONE : cnt_q + ONE;
    end

    // R5
    chan_hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_rst |=> (cnt_q == '0));
    // R4
    chan_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !hold_rst) |=> $stable(cnt_q));
    // R9
    chan_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act_reload) |=> (cnt_q == '0));
    // R6
    chan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && !hold_rst && !hit) |=>
        (cnt_q == ($past(down) ? $past(cnt_q) - ONE : $past(cnt_q) + ONE)));

endmodule

// File: rtl/mtm_timer.sv
// Multi-channel match timer top: register bank with four write modes per
// slot, shared prescaler, NCH counter channels, flags and a level interrupt.
// Assumes a synchronous single-cycle bus; reads are combinational.
module mtm_timer #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    import mtm_pkg::*;

    localparam int SLOT_W = ADDR_W - 4;
    localparam int FW     = NCH + 1;
    localparam int CW     = 2 * NCH;
    localparam int DW     = 4 * NCH;
    localparam int MW     = 3 * NCH;

    logic [SLOT_W-1:0] slot;
    wmode_e            wmode;
    logic [NSLOT-1:0]  wsel;
    logic              unused_addr;

    logic [FW-1:0]     flag_q, flag_d;
    logic [CW-1:0]     ctrl_q, ctrl_d;
    logic [DW-1:0]     dir_q, dir_d;
    logic [CNT_W-1:0]  pre_q, pre_d;
    logic [MW-1:0]     mctl_q, mctl_d;
    logic [CNT_W-1:0]  mval_q [NCH];
    logic [CNT_W-1:0]  mval_d [NCH];

    logic [CNT_W-1:0]  cnt_w [NCH];
    logic [NCH-1:0]    hit, halt_evt, int_en;
    logic [CNT_W-1:0]  pc_w;
    logic              tick;

    assign slot        = bus_addr[ADDR_W-1:4];
    assign wmode       = wmode_e'(bus_addr[3:2]);
    assign unused_addr = &{1'b0, bus_addr[1:0]};

    // One-hot write select per slot.
    always_comb begin
        for (int k = 0; k < NSLOT; k++)
            wsel[k] = bus_we && (slot == SLOT_W'(k));
    end

    // Shared prescaler, running while any channel is enabled.
    mtm_prescale #(.CNT_W(CNT_W)) presc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (|ctrl_q[NCH-1:0]),
        .clr   (|ctrl_q[CW-1:NCH]),
        .limit (pre_q),
        .pc    (pc_w),
        .tick  (tick)
    );

    // Channel instances and their per-channel control taps.
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign halt_evt[g] = hit[g] && mctl_q[3*g+2];
        assign int_en[g]   = mctl_q[3*g];

        mtm_channel #(.CNT_W(CNT_W)) chan_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (ctrl_q[g]),
            .hold_rst   (ctrl_q[NCH+g]),
            .tick       (tick),
            .down       (dir_q[4*g +: 4] == 4'd1),
            .mval       (mval_q[g]),
            .act_reload (mctl_q[3*g+1]),
            .act_halt   (mctl_q[3*g+2]),
            .cnt        (cnt_w[g]),
            .hit        (hit[g])
        );

        // R8
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> flag_q[g]);
        // R10
        halt_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            halt_evt[g] |=> !ctrl_q[g]);
        // R12
        irq_follows_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[g] && mctl_q[3*g]) |-> irq);
    end

    // Next register values from bus writes and hardware events.
    always_comb begin
        flag_d = flag_q;
        if (wsel[SL_FLAG])
            flag_d = (wmode == WM_REPLACE) ? (flag_q & ~bus_wdata[FW-1:0])
                                           : FW'(apply_write(32'(flag_q), bus_wdata, wmode));
        flag_d = flag_d | {1'b0, hit};

        ctrl_d = wsel[SL_CTRL] ? CW'(apply_write(32'(ctrl_q), bus_wdata, wmode)) : ctrl_q;
        ctrl_d = ctrl_d & ~{{NCH{1'b0}}, halt_evt};

        dir_d  = wsel[SL_DIR]  ? DW'(apply_write(32'(dir_q), bus_wdata, wmode))    : dir_q;
        pre_d  = wsel[SL_PRE]  ? CNT_W'(apply_write(32'(pre_q), bus_wdata, wmode)) : pre_q;
        mctl_d = wsel[SL_MCTL] ? MW'(apply_write(32'(mctl_q), bus_wdata, wmode))   : mctl_q;

        for (int i = 0; i < NCH; i++)
            mval_d[i] = wsel[SL_MR0+i] ? CNT_W'(apply_write(32'(mval_q[i]), bus_wdata, wmode))
                                       : mval_q[i];
    end

    // Register bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            ctrl_q <= '0;
            dir_q  <= '0;
            pre_q  <= '0;
            mctl_q <= '0;
            for (int i = 0; i < NCH; i++) mval_q[i] <= '0;
        end else begin
            flag_q <= flag_d;
            ctrl_q <= ctrl_d;
            dir_q  <= dir_d;
            pre_q  <= pre_d;
            mctl_q <= mctl_d;
            for (int i = 0; i < NCH; i++) mval_q[i] <= mval_d[i];
        end
    end

    // Read multiplexer: the stored value of the addressed slot.
    always_comb begin
        bus_rdata = '0;
        if (slot == SLOT_W'(SL_FLAG)) bus_rdata = 32'(flag_q);
        if (slot == SLOT_W'(SL_CTRL)) bus_rdata = 32'(ctrl_q);
        if (slot == SLOT_W'(SL_DIR))  bus_rdata = 32'(dir_q);
        if (slot == SLOT_W'(SL_PRE))  bus_rdata = 32'(pre_q);
        if (slot == SLOT_W'(SL_PCNT)) bus_rdata = 32'(pc_w);
        if (slot == SLOT_W'(SL_MCTL)) bus_rdata = 32'(mctl_q);
        for (int i = 0; i < NCH; i++) begin
            if (slot == SLOT_W'(SL_CNT0 + i)) bus_rdata = 32'(cnt_w[i]);
            if (slot == SLOT_W'(SL_MR0 + i))  bus_rdata = 32'(mval_q[i]);
        end
    end

    // Level interrupt from enabled match flags.
    assign irq = |(flag_q[NCH-1:0] & int_en);

endmodule

// File: tb/mtm_timer_tb.sv
// Self-checking bench for mtm_timer with an 8-bit counter configuration.
module mtm_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 8;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mtm_timer #(.CNT_W(CW), .ADDR_W(12)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One write; called at a falling edge, returns at the next falling edge.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    // Combinational read away from the clock edge.
    task automatic rd_chk(input string tag, input string what,
                          input logic [11:0] a, input logic [31:0] exp);
        addr = a; we = 1'b0;
        #1;
        chk(tag, what, rdata, exp);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a; we = 1'b0;
        #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog all-R actual=timeout expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, v2, expv;
        logic [15:0] pats [4];
        int st, e;
        pats[0] = 16'hA5C3; pats[1] = 16'h0F0F; pats[2] = 16'hFFFF; pats[3] = 16'h1234;

        idle(3);
        rst_n = 1'b1;

        // R1: every slot reads zero after reset
        for (int s = 0; s < 14; s++)
            rd_chk("R1", "reset slot", 12'(s << 4), 32'h0);
        chk("R1", "irq after reset", {31'b0, irq}, 32'h0);

        // R2: sweep write modes on the direction slot
        for (int b = 0; b < 4; b++)
            for (int p = 0; p < 4; p++)
                for (int m = 0; m < 4; m++) begin
                    wr(12'h020, 32'(pats[b]));
                    wr(12'h020 | 12'(m << 2), 32'(pats[p]));
                    case (m)
                        0: expv = 32'(pats[p]);
                        1: expv = 32'(pats[b] | pats[p]);
                        2: expv = 32'(pats[b] & ~pats[p]);
                        default: expv = 32'(pats[b] ^ pats[p]);
                    endcase
                    rd_chk("R2", "write mode", 12'h020 | 12'(((m + 1) % 4) << 2), expv);
                end
        wr(12'h020, 32'h0);

        // R3: prescaler sweep, counter = n/(p+1), prescale count = n%(p+1)
        for (int p = 0; p < 4; p++) begin
            wr(12'h010, 32'h10);
            wr(12'h070, 32'(p));
            wr(12'h010, 32'h01);
            st = cyc;
            for (int k = 0; k < 12; k++) begin
                e = cyc - st;
                rd_chk("R3", "counter0 vs prescale", 12'h030, 32'((e / (p + 1)) % 256));
                rd_chk("R3", "prescale count", 12'h080, 32'(e % (p + 1)));
                idle(1);
            end
            // R4: disabled counter and prescale count keep their values
            wr(12'h010, 32'h0);
            rd(12'h030, v);
            rd(12'h080, v2);
            idle(5);
            rd_chk("R4", "counter0 held", 12'h030, v);
            rd_chk("R4", "prescale count held", 12'h080, v2);
        end

        // R5: hold-reset bit clears and holds, counting resumes after release
        wr(12'h010, 32'h10);
        wr(12'h070, 32'h0);
        wr(12'h010, 32'h01);
        idle(6);
        rd_chk("R5", "counter0 before hold", 12'h030, 32'd6);
        wr(12'h014, 32'h10);
        idle(4);
        rd_chk("R5", "counter0 held zero", 12'h030, 32'd0);
        rd_chk("R5", "prescale count zero", 12'h080, 32'd0);
        rd_chk("R5", "control kept", 12'h010, 32'h11);
        wr(12'h018, 32'h10);
        st = cyc;
        idle(7);
        rd_chk("R5", "counter0 resumed", 12'h030, 32'(cyc - st));

        // R6: channel 1 down (field 1), channel 2 up (field 2), wrap
        wr(12'h010, 32'hF0);
        wr(12'h020, 32'h0210);
        wr(12'h010, 32'h06);
        st = cyc;
        idle(3);
        e = cyc - st;
        rd_chk("R6", "counter1 down", 12'h040, 32'((1024 - e) % 256));
        rd_chk("R6", "counter2 up field 2", 12'h050, 32'(e % 256));
        idle(297);
        e = cyc - st;
        rd_chk("R6", "counter1 down wrap", 12'h040, 32'((1024 - e) % 256));
        rd_chk("R6", "counter2 up wrap", 12'h050, 32'(e % 256));
        wr(12'h010, 32'h0);

        // R7: read-only and unused slots
        rd(12'h040, v);
        wr(12'h040, 32'h55);
        wr(12'h044, 32'hFF);
        rd_chk("R7", "counter1 write ignored", 12'h040, v);
        rd(12'h080, v2);
        wr(12'h080, 32'h3);
        rd_chk("R7", "prescale count write ignored", 12'h080, v2);
        wr(12'h0E0, 32'hFFFF);
        rd_chk("R7", "unused slot", 12'h0E0, 32'h0);

        // R8 R9 R12: match 4 with reload and interrupt on channel 0
        wr(12'h010, 32'hF0);
        wr(12'h000, 32'h1F);
        wr(12'h0A0, 32'd4);
        wr(12'h090, 32'h3);
        wr(12'h010, 32'h01);
        st = cyc;
        for (int k = 0; k < 13; k++) begin
            e = cyc - st;
            rd_chk("R9", "counter0 period", 12'h030, 32'(e % 5));
            rd_chk("R8", "flag0", 12'h000, (e >= 5) ? 32'h1 : 32'h0);
            chk("R12", "irq from flag0", {31'b0, irq}, (e >= 5) ? 32'h1 : 32'h0);
            idle(1);
        end

        // R11: flag writes
        wr(12'h010, 32'h0);
        wr(12'h000, 32'h0);
        rd_chk("R11", "replace write of 0 keeps flag", 12'h000, 32'h1);
        wr(12'h000, 32'h1);
        rd_chk("R11", "replace write of 1 clears", 12'h000, 32'h0);
        chk("R12", "irq after clear", {31'b0, irq}, 32'h0);
        wr(12'h004, 32'h10);
        rd_chk("R11", "OR sets status bit", 12'h000, 32'h10);
        chk("R12", "status bit excluded", {31'b0, irq}, 32'h0);
        wr(12'h00C, 32'h11);
        rd_chk("R11", "XOR flips", 12'h000, 32'h01);
        chk("R12", "irq after XOR", {31'b0, irq}, 32'h1);
        wr(12'h008, 32'h01);
        rd_chk("R11", "ANDN clears", 12'h000, 32'h0);
        // R11: match and clear on the same edge, match wins
        wr(12'h010, 32'hF0);
        wr(12'h010, 32'h01);
        idle(4);
        wr(12'h000, 32'h01);
        rd_chk("R11", "match beats clear", 12'h000, 32'h1);
        wr(12'h010, 32'h0);
        wr(12'h000, 32'h1F);

        // R10: halt on match for channel 2
        wr(12'h010, 32'hF0);
        wr(12'h020, 32'h0);
        wr(12'h0C0, 32'd3);
        wr(12'h090, 32'h100);
        wr(12'h010, 32'h04);
        idle(10);
        rd_chk("R10", "counter2 halted at match", 12'h050, 32'd3);
        rd_chk("R10", "enable2 cleared", 12'h010, 32'h0);
        rd_chk("R8", "flag2", 12'h000, 32'h4);
        chk("R12", "flag2 without enable", {31'b0, irq}, 32'h0);
        wr(12'h094, 32'h40);
        chk("R12", "flag2 with enable", {31'b0, irq}, 32'h1);
        rd_chk("R2", "match control via ANDN address", 12'h098, 32'h140);

        // R10 with R9: halt plus reload on channel 3
        wr(12'h008, 32'h1F);
        wr(12'h010, 32'hF0);
        wr(12'h0D0, 32'd2);
        wr(12'h090, 32'hC00);
        wr(12'h010, 32'h08);
        idle(2);
        rd_chk("R10", "counter3 before match", 12'h060, 32'd2);
        idle(6);
        rd_chk("R10", "counter3 reloaded and halted", 12'h060, 32'd0);
        rd_chk("R10", "enable3 cleared", 12'h010, 32'h0);
        rd_chk("R8", "flag3", 12'h000, 32'h8);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule